// File: doc/BRIEF.md
# Receive Character Queue with Idle Time-out

This block is the receive-side buffer of a 16550-class serial port. A receiver shifter upstream hands it one byte at a time with a valid strobe, plus a separate pulse at the middle of each stop bit. The bytes are queued, and the block raises a level interrupt request once enough of them are waiting. A host read strobe pops the oldest byte onto a registered data output. A data-ready status bit stays high while anything is left in the queue.

A one-byte control write sets three things. It turns queueing on or off; when off, the block holds a single byte. It picks one of four occupancy thresholds. It can flush the queue. The block also guards against bytes that sit unread below the threshold. An idle counter runs on the 16x bit-rate tick. It raises a time-out request after four whole character frames pass with no new stop bit and no read. The frame length follows the current word length, the parity setting and the stop length.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset, rd_data is 0, all four flags (data_ready, level_irq, timeout_irq, overrun) are low, and queueing is off.
- R2: With queueing on (ctl_wdata bit 0 = 1), up to 16 bytes are held and returned oldest first. rd_data takes the popped byte on the clock edge that samples rd_strobe. A read strobe while empty leaves rd_data and all flags unchanged.
- R3: data_ready is high exactly while at least one byte is held, and it drops only on the read that takes the last byte.
- R4: ctl_wdata bits 7:6 pick the threshold: 00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes. level_irq is high while the held count is at or above the threshold. Bytes are still accepted above the threshold until 16 are held.
- R5: A byte that arrives while the buffer is full, with no pop in the same cycle, is dropped and sets overrun. overrun stays set until a flush or reset.
- R6: A control write flushes the buffer when bit 1 is set or when bit 0 differs from the current queueing state. A flush empties the buffer and clears overrun and timeout_irq.
- R7: With queueing off, the block holds a single byte, level_irq follows data_ready, and timeout_irq never asserts.
- R8: The time-out fires after 4 x (16 x (1 + N + P) + S) ticks, where:
  - N is 5 + fmt_len (fmt_len 00..11 gives 5..8 data bits);
  - P is fmt_parity;
  - S is 16, 24 or 32 ticks for fmt_stop = 00, 01, or 1x.
  timeout_irq rises on the edge that consumes the last of those ticks.
- R9: A stop-bit-middle pulse or a read strobe restarts the idle count. A read strobe also clears timeout_irq.
- R10: timeout_irq is never high while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_valid | input | 1 | Byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| rx_stop_mid | input | 1 | Pulse at the middle of each stop bit |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: [0] enable, [1] flush, [7:6] threshold |
| fmt_len | input | 2 | Word length, 00 = 5 bits to 11 = 8 bits |
| fmt_parity | input | 1 | Parity bit present |
| fmt_stop | input | 2 | Stop length: 00 = 1, 01 = 1.5, 1x = 2 bits |
| rd_strobe | input | 1 | Host read of the holding register |
| rd_data | output | 8 | Byte returned by the last read |
| data_ready | output | 1 | At least one byte held |
| level_irq | output | 1 | Occupancy at or above threshold |
| timeout_irq | output | 1 | Unread data idle for four frames |
| overrun | output | 1 | Sticky: a byte was dropped when full |

## Verification
The bench fills the buffer one byte at a time under every threshold code. It checks level_irq at each count, so an off-by-one comparison or a wrong code mapping shows up on the exact byte where it flips. It then pushes a seventeenth byte and drains all sixteen, which catches pointer wrap errors and a design that overwrites instead of dropping. The idle counter is swept across all 24 line formats, with the flag checked one edge before and on the expected edge; a miscounted parity bit or half stop bit moves that edge. Separate runs restart the count with a stop-bit pulse and with a read. Further runs flush while the flag is high, wait on an empty buffer, and wait with queueing off; each exposes a counter that ignores one of these conditions.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef enum logic [1:0] {
    TRIG_SINGLE  = 2'b00,
    TRIG_QUARTER = 2'b01,
    TRIG_HALF    = 2'b10,
    TRIG_NEAR    = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    STOP_ONE  = 2'b00,
    STOP_ONE5 = 2'b01,
    STOP_TWO  = 2'b10,
    STOP_TWOB = 2'b11
  } stop_e;

  // Threshold in entries for a queue of the given depth.
  function automatic int unsigned trig_entries(trig_e sel, int unsigned depth);
    case (sel)
      TRIG_SINGLE:  return 1;
      TRIG_QUARTER: return depth / 4;
      TRIG_HALF:    return depth / 2;
      default:      return depth - 2;
    endcase
  endfunction

  // Stop length in oversampling ticks.
  function automatic int unsigned stop_ticks(stop_e sel, int unsigned osr);
    case (sel)
      STOP_ONE:  return osr;
      STOP_ONE5: return osr + osr / 2;
      default:   return 2 * osr;
    endcase
  endfunction

endpackage

// File: rtl/rxbuf_mem.sv
module rxbuf_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // Write port: no reset, so a RAM primitive can be inferred.
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  // Synchronous read port with output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  input  logic          q_en,
  input  trig_e         trig_sel,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          not_empty,
  output logic          above_trig,
  output logic          ovr_flag
);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, count_nxt;
  logic [CW-1:0] cap, level;
  logic          empty, full_eff, do_push, do_pop;

  always_comb begin
    cap   = q_en ? CW'(DEPTH) : CW'(1);
    level = q_en ? CW'(trig_entries(trig_sel, DEPTH)) : CW'(1);
  end

  assign empty    = (count_q == '0);
  assign do_pop   = pop_req && !empty && !flush;
  assign full_eff = (count_q >= cap) && !do_pop;
  assign do_push  = push_req && !full_eff && !flush;

  assign wr_en   = do_push;
  assign wr_addr = wptr_q;
  assign rd_en   = do_pop;
  assign rd_addr = rptr_q;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (flush) begin
      count_nxt = '0;
    end else begin
      count_nxt = count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      not_empty  <= 1'b0;
      above_trig <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      count_q    <= count_nxt;
      not_empty  <= (count_nxt != '0);
      above_trig <= (count_nxt >= level);
      if (flush) begin
        wptr_q   <= '0;
        rptr_q   <= '0;
        ovr_flag <= 1'b0;
      end else begin
        if (do_push) begin
          wptr_q <= bump(wptr_q);
        end
        if (do_pop) begin
          rptr_q <= bump(rptr_q);
        end
        if (push_req && full_eff) begin
          ovr_flag <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rxbuf_idle.sv
module rxbuf_idle
  import rxbuf_pkg::*;
#(
  parameter int unsigned OSR   = 16,
  parameter int unsigned CHARS = 4,
  localparam int unsigned MAXL = CHARS * OSR * 12,
  localparam int unsigned TW   = $clog2(MAXL + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       restart,
  input  logic       drop,
  input  logic       hold,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  stop_e      stop_sel,
  output logic       expired
);

  int unsigned   frame_bits;
  logic [TW-1:0] lim_d, lim_q, cnt_q;

  // Frame length recomputed from the line settings every cycle.
  always_comb begin
    frame_bits = 32'd6 + 32'(len_sel) + 32'(par_en);
    lim_d      = TW'(CHARS * (OSR * frame_bits + stop_ticks(stop_sel, OSR)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q   <= '0;
      cnt_q   <= '0;
      expired <= 1'b0;
    end else begin
      lim_q <= lim_d;
      if (hold || drop) begin
        cnt_q   <= '0;
        expired <= 1'b0;
      end else if (restart) begin
        cnt_q <= '0;
      end else if (tick && !expired) begin
        if (cnt_q == lim_q - 1'b1) begin
          expired <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned OSR    = 16,
  parameter int unsigned CHARS  = 4,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_stop_mid,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic [1:0]        fmt_len,
  input  logic              fmt_parity,
  input  logic [1:0]        fmt_stop,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_ready,
  output logic              level_irq,
  output logic              timeout_irq,
  output logic              overrun
);

  logic          q_en_q;
  trig_e         trig_q;
  logic          flush;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          ctl_rsvd_unused;

  assign ctl_rsvd_unused = ^ctl_wdata[5:2];

  // Flush on explicit request or on a change of queueing state.
  assign flush = ctl_we && (ctl_wdata[1] || (ctl_wdata[0] != q_en_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      q_en_q <= 1'b0;
      trig_q <= TRIG_SINGLE;
    end else if (ctl_we) begin
      q_en_q <= ctl_wdata[0];
      trig_q <= trig_e'(ctl_wdata[7:6]);
    end
  end

  rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .push_req   (rx_valid),
    .pop_req    (rd_strobe),
    .flush      (flush),
    .q_en       (q_en_q),
    .trig_sel   (trig_q),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .not_empty  (data_ready),
    .above_trig (level_irq),
    .ovr_flag   (overrun)
  );

  rxbuf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (rx_byte),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  rxbuf_idle #(.OSR(OSR), .CHARS(CHARS)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick16),
    .restart  (rx_stop_mid || rd_strobe),
    .drop     (rd_strobe || flush),
    .hold     (!q_en_q || !data_ready),
    .len_sel  (fmt_len),
    .par_en   (fmt_parity),
    .stop_sel (stop_e'(fmt_stop)),
    .expired  (timeout_irq)
  );

endmodule

// File: rtl/rx_char_buffer_chk.sv
module rx_char_buffer_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic       rd_strobe,
  input logic       data_ready,
  input logic       level_irq,
  input logic       timeout_irq,
  input logic       overrun
);

  AST_TMO_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    timeout_irq |-> data_ready); // R10

  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    level_irq |-> data_ready); // R4

  AST_PUSH_LEAVES_DATA: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !ctl_we) |=> data_ready); // R3

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ctl_we) |=> overrun); // R5

  AST_RD_DROPS_TMO: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !timeout_irq); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[1]) |=> (!data_ready && !level_irq && !overrun)); // R6

endmodule

bind rx_char_buffer rx_char_buffer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_valid    (rx_valid),
  .ctl_we      (ctl_we),
  .ctl_wdata   (ctl_wdata),
  .rd_strobe   (rd_strobe),
  .data_ready  (data_ready),
  .level_irq   (level_irq),
  .timeout_irq (timeout_irq),
  .overrun     (overrun)
);

// File: tb/sim_rx_char_buffer.sv
module sim_rx_char_buffer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_stop_mid = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [1:0] fmt_len = '0;
  logic       fmt_parity = 1'b0;
  logic [1:0] fmt_stop = '0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, level_irq, timeout_irq, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_char_buffer u0 (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_stop_mid(rx_stop_mid), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .fmt_len(fmt_len), .fmt_parity(fmt_parity), .fmt_stop(fmt_stop),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .data_ready(data_ready),
    .level_irq(level_irq), .timeout_irq(timeout_irq), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = d; rx_stop_mid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_stop_mid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  function automatic int exp_lim(int db, int p, int s);
    int st;
    st = (s == 0) ? 16 : ((s == 1) ? 24 : 32);
    return 4 * (16 * (1 + 5 + db + p) + st);
  endfunction

  function automatic int exp_level(int t);
    return (t == 0) ? 1 : ((t == 1) ? 4 : ((t == 2) ? 8 : 14));
  endfunction

  // Wait lim ticks; the flag must be low one edge early and high on time.
  task automatic wait_expiry(input string req, input int lim);
    repeat (lim - 1) @(negedge clk);
    chk({req, " early"}, int'(timeout_irq), 0);
    @(negedge clk);
    chk({req, " on time"}, int'(timeout_irq), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 data_ready", int'(data_ready), 0);
    chk("R1 level_irq", int'(level_irq), 0);
    chk("R1 timeout_irq", int'(timeout_irq), 0);
    chk("R1 overrun", int'(overrun), 0);

    // R7 single holding register with queueing off
    push(8'h11);
    chk("R7 ready", int'(data_ready), 1);
    chk("R7 level follows ready", int'(level_irq), 1);
    push(8'h22);
    chk("R5 R7 second byte overruns", int'(overrun), 1);
    pop();
    chk("R7 holds first byte", int'(rd_data), 8'h11);
    chk("R7 empty after read", int'(data_ready), 0);
    chk("R5 overrun sticky", int'(overrun), 1);
    ctl(8'h02);
    chk("R6 flush clears overrun", int'(overrun), 0);

    // R4 R2 R3 R5 threshold sweep with full fill and drain
    for (int t = 0; t < 4; t++) begin
      ctl({2'(t), 6'b000011});
      chk("R6 flush on enable", int'(data_ready), 0);
      for (int i = 1; i <= 16; i++) begin
        push(8'((t << 5) + i));
        chk("R4 level at count", int'(level_irq), (i >= exp_level(t)) ? 1 : 0);
        chk("R3 ready while filling", int'(data_ready), 1);
      end
      chk("R5 no overrun at exactly full", int'(overrun), 0);
      push(8'hEE);
      chk("R5 drop when full", int'(overrun), 1);
      for (int i = 1; i <= 16; i++) begin
        pop();
        chk("R2 order", int'(rd_data), (t << 5) + i);
        chk("R3 ready while draining", int'(data_ready), (i < 16) ? 1 : 0);
      end
      chk("R5 overrun held after drain", int'(overrun), 1);
    end

    // R2 empty read changes nothing
    pop();
    chk("R2 empty read keeps data", int'(rd_data), (3 << 5) + 16);
    chk("R2 empty read keeps ready", int'(data_ready), 0);

    // R5 R6 rewriting same enable without flush bit keeps overrun
    ctl(8'hC1);
    chk("R5 overrun survives plain write", int'(overrun), 1);
    ctl(8'hC7);
    chk("R6 flush bit clears overrun", int'(overrun), 0);
    push(8'h01); push(8'h02); push(8'h03);
    ctl(8'h00);
    chk("R6 enable change flushes", int'(data_ready), 0);

    // R8 time-out length over all line formats
    ctl(8'h07);
    for (int db = 0; db < 4; db++) begin
      for (int p = 0; p < 2; p++) begin
        for (int s = 0; s < 3; s++) begin
          fmt_len = 2'(db); fmt_parity = 1'(p); fmt_stop = 2'(s);
          push(8'h5A);
          tick16 = 1'b1;
          wait_expiry("R8", exp_lim(db, p, s));
          tick16 = 1'b0;
          pop();
          chk("R9 read clears time-out", int'(timeout_irq), 0);
        end
      end
    end

    // R9 restart by stop-bit pulse and by read
    fmt_len = 2'd3; fmt_parity = 1'b0; fmt_stop = 2'd0;
    push(8'hA1);
    tick16 = 1'b1;
    repeat (300) @(negedge clk);
    push(8'hA2);
    wait_expiry("R9 stop restart", exp_lim(3, 0, 0));
    pop();
    chk("R9 read drops flag", int'(timeout_irq), 0);
    chk("R3 still one byte", int'(data_ready), 1);
    wait_expiry("R9 read restart", exp_lim(3, 0, 0));
    pop();
    chk("R3 empty", int'(data_ready), 0);

    // R10 empty buffer never times out
    repeat (1000) @(negedge clk);
    chk("R10 no time-out when empty", int'(timeout_irq), 0);

    // R6 flush drops a raised time-out
    tick16 = 1'b0;
    fmt_len = 2'd0;
    push(8'h77);
    tick16 = 1'b1;
    wait_expiry("R8 short frame", exp_lim(0, 0, 0));
    ctl(8'h03);
    chk("R6 flush clears time-out", int'(timeout_irq), 0);
    chk("R6 flush empties", int'(data_ready), 0);

    // R7 no time-out with queueing off
    ctl(8'h00);
    push(8'h99);
    repeat (700) @(negedge clk);
    chk("R7 no time-out when off", int'(timeout_irq), 0);
    chk("R7 byte still held", int'(data_ready), 1);
    tick16 = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule